// File: doc/BRIEF.md
# Receive Character Holding Queue with Automatic RTS

This block sits on the receive path of an asynchronous serial port, between the deserializer that assembles characters and the CPU register interface. Each finished character goes into a three-entry first-in first-out queue. When every queue entry is taken, the receive shift register holds one more character. That character moves into the queue on the clock after a slot frees up.

The block raises a sticky overrun flag when the start bit of a character arrives while the shift register already holds a pending character. In automatic flow-control mode it drops RTS when a start bit arrives while the queue is full, and raises RTS again once a slot is free. The CPU can drain the queue while the receiver is disabled. A receiver reset clears the queue and all receive status, and keeps further characters out until the receiver has been switched off and then on again.

Top module: `rx_hold_fifo`

## Requirements
- R1: The queue holds DEPTH (3) characters in arrival order. `rd_data` shows the oldest entry. A `rd_stb` pulse removes it. `fifo_ready` is high when at least one entry is held, and `fifo_full` is high when all DEPTH entries are held. After a read while full, `fifo_full` is low on the next cycle.
- R2: A character that completes while the queue is full is kept in the shift stage. It enters the queue at the first clock edge where the registered occupancy is below DEPTH. It lands behind the older entries.
- R3: A character that completes while the shift stage already holds one leaves the queue unchanged. The newer character replaces the held one, and the held one is lost.
- R4: `overrun` goes high at the clock after `start_det` is seen while the shift stage holds a character. It stays high until an `err_clr` pulse or a receiver reset.
- R5: With `auto_rts_en` high, `rts` goes low at the clock after `start_det` is seen while the queue is full. It returns high at the first clock edge where the queue is not full. A start bit seen while the queue is not full leaves `rts` high.
- R6: With `auto_rts_en` low, `rts` is held high.
- R7: While `rx_en` is low, reads still remove entries, and `start_det` and `char_done` have no effect.
- R8: A `rx_rst` pulse empties the queue, drops any held character, clears `overrun`, drives `rts` high and clears `irq` on the next cycle.
- R9: After `rx_rst`, characters are ignored until `rx_en` has been seen low for at least one clock and is high again.
- R10: `irq` is high exactly when `rx_irq_en` is high and the queue holds at least one character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| rx_en | input | 1 | Receiver enable level |
| rx_rst | input | 1 | Receiver reset command pulse |
| auto_rts_en | input | 1 | Automatic RTS flow-control mode |
| rx_irq_en | input | 1 | Receive interrupt enable |
| start_det | input | 1 | Valid start bit detected strobe |
| char_done | input | 1 | Character complete strobe |
| char_data | input | DATA_W | Completed character |
| rd_stb | input | 1 | CPU read strobe, removes the oldest entry |
| err_clr | input | 1 | CPU error-reset command, clears overrun |
| rd_data | output | DATA_W | Oldest queued character |
| fifo_ready | output | 1 | Queue holds at least one character |
| fifo_full | output | 1 | Queue holds DEPTH characters |
| overrun | output | 1 | Sticky overrun flag |
| rts | output | 1 | Request-to-send, high means send allowed |
| irq | output | 1 | Receive interrupt request |

## Verification
Every strobe acts at the next rising edge. The status outputs decode registered state, so their effect is visible one cycle after the strobe. The one exception is a character waiting in the shift stage: after a read from a full queue it shows up in the queue two edges later, because the transfer waits for the registered occupancy to drop. The bench changes inputs on the falling edge and samples outputs on the following falling edge, one edge after each stimulus. For the delayed transfer it adds an idle vector in between and checks the vector after that.

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_rst,
  input  logic              auto_rts_en,
  input  logic              rx_irq_en,
  input  logic              start_det,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              rd_stb,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              fifo_ready,
  output logic              fifo_full,
  output logic              overrun,
  output logic              rts,
  output logic              irq
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] hold_data;
  logic              hold_vld, blocked, ovr_q, rts_q;

  logic accept, space, pop, take, push;
  logic [DATA_W-1:0] push_data;

  assign accept    = rx_en && !blocked;
  assign space     = count < CNT_W'(DEPTH);
  assign pop       = rd_stb && (count != '0);
  assign take      = accept && char_done;
  assign push      = space && (hold_vld || take);
  assign push_data = hold_vld ? hold_data : char_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      count     <= '0;
      hold_data <= '0;
      hold_vld  <= 1'b0;
      blocked   <= 1'b0;
      ovr_q     <= 1'b0;
      rts_q     <= 1'b1;
    end else if (rx_rst) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      hold_vld <= 1'b0;
      blocked  <= 1'b1;
      ovr_q    <= 1'b0;
      rts_q    <= 1'b1;
    end else begin
      if (!rx_en) blocked <= 1'b0;
      if (push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
      if (take && (hold_vld || !space)) hold_data <= char_data;
      hold_vld <= take ? (hold_vld || !space) : (hold_vld && !space);
      if (accept && start_det && hold_vld) ovr_q <= 1'b1;
      else if (err_clr)                    ovr_q <= 1'b0;
      if (accept && start_det && !space) rts_q <= 1'b0;
      else if (space)                    rts_q <= 1'b1;
    end
  end

  assign rd_data    = mem[rd_ptr];
  assign fifo_ready = count != '0;
  assign fifo_full  = !space;
  assign overrun    = ovr_q;
  assign rts        = auto_rts_en ? rts_q : 1'b1;
  assign irq        = rx_irq_en && fifo_ready;
endmodule

// File: rtl/rx_hold_fifo_chk.sv
module rx_hold_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic rx_rst,
  input logic start_det,
  input logic rd_stb,
  input logic err_clr,
  input logic auto_rts_en,
  input logic fifo_ready,
  input logic fifo_full,
  input logic overrun,
  input logic rts,
  input logic irq,
  input logic hold_vld,
  input logic accept
);
  a_r8_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> (!fifo_ready && !overrun && !irq && rts));

  a_r4_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_clr && !rx_rst) |=> overrun);

  a_r4_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && start_det && hold_vld && !rx_rst) |=> overrun);

  a_r5_rts_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && accept && start_det && fifo_full && !rx_rst) |=> (!rts || !auto_rts_en));

  a_r5_rts_up: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_full |=> rts);

  a_r1_pop_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && fifo_full && !rx_rst) |=> !fifo_full);

  a_r7_off_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !fifo_ready && !hold_vld) |=> !fifo_ready);
endmodule

bind rx_hold_fifo rx_hold_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_rst(rx_rst),
  .start_det(start_det), .rd_stb(rd_stb), .err_clr(err_clr),
  .auto_rts_en(auto_rts_en), .fifo_ready(fifo_ready), .fifo_full(fifo_full),
  .overrun(overrun), .rts(rts), .irq(irq), .hold_vld(hold_vld), .accept(accept)
);

// File: tb/rx_hold_fifo_bench.sv
module rx_hold_fifo_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b0, rx_rst = 1'b0, auto_rts_en = 1'b1, rx_irq_en = 1'b1;
  logic start_det = 1'b0, char_done = 1'b0, rd_stb = 1'b0, err_clr = 1'b0;
  logic [7:0] char_data = '0, rd_data;
  logic fifo_ready, fifo_full, overrun, rts, irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_hold_fifo u_rx_hold_fifo (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_rst(rx_rst),
    .auto_rts_en(auto_rts_en), .rx_irq_en(rx_irq_en), .start_det(start_det),
    .char_done(char_done), .char_data(char_data), .rd_stb(rd_stb),
    .err_clr(err_clr), .rd_data(rd_data), .fifo_ready(fifo_ready),
    .fifo_full(fifo_full), .overrun(overrun), .rts(rts), .irq(irq)
  );

  // st, dn, rd, data | expected count, overrun, rts, head
  localparam logic [22:0] VECS [12] = '{
    {1'b0,1'b1,1'b0,8'h11, 2'd1,1'b0,1'b1,8'h11},  // R1
    {1'b0,1'b1,1'b0,8'h22, 2'd2,1'b0,1'b1,8'h11},
    {1'b0,1'b1,1'b0,8'h33, 2'd3,1'b0,1'b1,8'h11},
    {1'b1,1'b0,1'b0,8'h00, 2'd3,1'b0,1'b0,8'h11},  // R5 drop
    {1'b0,1'b1,1'b0,8'h44, 2'd3,1'b0,1'b0,8'h11},  // R2 held
    {1'b1,1'b0,1'b0,8'h00, 2'd3,1'b1,1'b0,8'h11},  // R4 set
    {1'b0,1'b1,1'b0,8'h55, 2'd3,1'b1,1'b0,8'h11},  // R3 replace
    {1'b0,1'b0,1'b1,8'h00, 2'd2,1'b1,1'b0,8'h22},
    {1'b0,1'b0,1'b0,8'h00, 2'd3,1'b1,1'b1,8'h22},  // R2 move, R5 up
    {1'b0,1'b0,1'b1,8'h00, 2'd2,1'b1,1'b1,8'h33},
    {1'b0,1'b0,1'b1,8'h00, 2'd1,1'b1,1'b1,8'h55},  // R3 44 lost
    {1'b0,1'b0,1'b1,8'h00, 2'd0,1'b1,1'b1,8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
    start_det = 0; char_done = 0; rd_stb = 0; err_clr = 0; rx_rst = 0;
  endtask

  task automatic send(input logic [7:0] d);
    char_done = 1; char_data = d; tick();
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=done");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset ready", fifo_ready, 0);
    chk("R1 reset full", fifo_full, 0);
    chk("R4 reset ovr", overrun, 0);
    chk("R5 reset rts", rts, 1);
    chk("R10 reset irq", irq, 0);
    rx_en = 1;
    tick();

    for (int i = 0; i < 12; i++) begin
      logic [22:0] v;
      v = VECS[i];
      start_det = v[22]; char_done = v[21]; rd_stb = v[20]; char_data = v[19:12];
      tick();
      chk($sformatf("R1 ready v%0d", i), fifo_ready, v[11:10] != 0);
      chk($sformatf("R1 full v%0d", i), fifo_full, v[11:10] == 3);
      chk($sformatf("R4 ovr v%0d", i), overrun, v[9]);
      chk($sformatf("R5 rts v%0d", i), rts, v[8]);
      chk($sformatf("R10 irq v%0d", i), irq, v[11:10] != 0);
      if (v[11:10] != 0) chk($sformatf("R2 head v%0d", i), rd_data, v[7:0]);
    end

    err_clr = 1; tick();
    chk("R4 err_clr", overrun, 0);

    send(8'h61); send(8'h62); send(8'h63);
    auto_rts_en = 0;
    start_det = 1; tick();
    chk("R6 rts forced high", rts, 1);
    rx_irq_en = 0; tick();
    chk("R10 irq masked", irq, 0);
    rx_irq_en = 1; tick();
    chk("R10 irq unmasked", irq, 1);
    auto_rts_en = 1;

    rx_en = 0;
    rd_stb = 1; tick();
    chk("R7 read while off", rd_data, 8'h62);
    send(8'h77);
    chk("R7 char ignored", fifo_full, 0);
    start_det = 1; tick();
    rd_stb = 1; tick();
    chk("R7 order", rd_data, 8'h63);
    rd_stb = 1; tick();
    chk("R7 drained", fifo_ready, 0);
    chk("R5 rts after drain", rts, 1);

    rx_en = 1; tick();
    send(8'h81); send(8'h82); send(8'h83);
    start_det = 1; tick();
    send(8'h84);
    start_det = 1; tick();
    chk("R4 ovr before rst", overrun, 1);
    chk("R5 rts low before rst", rts, 0);
    rx_rst = 1; tick();
    chk("R8 empty", fifo_ready, 0);
    chk("R8 ovr clear", overrun, 0);
    chk("R8 rts high", rts, 1);
    chk("R8 irq clear", irq, 0);
    tick();
    chk("R8 held char dropped", fifo_ready, 0);
    send(8'h88);
    chk("R9 blocked after rst", fifo_ready, 0);
    rx_en = 0; tick();
    rx_en = 1; tick();
    send(8'h99);
    chk("R9 accepted again", fifo_ready, 1);
    chk("R9 head", rd_data, 8'h99);
    start_det = 1; tick();
    chk("R5 start not full keeps rts", rts, 1);

    done = 1;
    finish_run();
  end
endmodule